// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides, byte by byte, whether an I2C slave is being addressed. It sits behind the bit-level receiver: the receiver reports Start (or Repeated Start) and Stop conditions and hands over each complete byte with a one-cycle strobe. The matcher treats the first byte after a Start as an address byte and compares it against a configured address under a per-bit don't-care mask. It handles 7-bit addressing, 10-bit addressing (a header byte followed by a low byte), the all-zero general call, and an optional rule that refuses reserved 7-bit addresses.

For every address byte it gives a one-cycle verdict (`ack_vld` with `ack_hit`), which the ACK driver uses to pull SDA low or leave it released. Once the slave is selected, `sel` and `rd_dir` give the data-phase direction. `gc_flag` and `ten_flag` are status flags that a Stop clears. A 10-bit match stays in force across a Repeated Start, so the master can turn the bus around with a single header byte that has R/W = 1.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is held, and on the first cycle after it, every output is 0.
- R2: One cycle after an address byte is strobed, `ack_vld` is 1 for one cycle and `ack_hit` gives the verdict. `ack_hit` is never 1 without `ack_vld`. Bytes strobed before any Start, or while the slave is selected, produce no `ack_vld`.
- R3: In 7-bit mode (`cfg_ten_bit`=0), byte bits 7:1 are compared with `cfg_addr[6:0]`. A `cfg_mask` bit of 1 in positions 6:1 makes that position don't-care. Address bit 0 is always compared exactly. On a hit, `sel` goes to 1 and `rd_dir` takes byte bit 0 (1 = slave transmits).
- R4: Byte 0x00 is a general call. It is hit only when `cfg_gc_en`=1, in either mode. A hit sets `gc_flag`, `sel`=1 and `rd_dir`=0. With `cfg_gc_en`=0 it is refused.
- R5: With `cfg_strict`=1 in 7-bit mode, a byte whose bits 7:4 are 0000 or 1111 (other than 0x00) is refused even if it matches the address. With `cfg_strict`=0 the same byte is compared normally.
- R6: In 10-bit mode, a first byte with bits 7:3 = 11110, bit 0 = 0, and bits 2:1 matching `cfg_addr[9:8]` (under `cfg_mask[9:8]`) is hit, and the matcher then waits for a low byte. Any other first byte except a general call is refused.
- R7: The 10-bit low byte is compared with `cfg_addr[7:0]` under `cfg_mask[7:0]`, where mask bit 0 is honoured. A hit sets `sel`=1, `rd_dir`=0 and `ten_flag`=1. A miss is refused.
- R8: With `ten_flag`=1, a matching header byte with bit 0 = 1 after a Repeated Start is hit on its own and sets `sel`=1 and `rd_dir`=1. With `ten_flag`=0 the same byte is refused.
- R9: A Stop clears `sel`, `rd_dir`, `gc_flag` and `ten_flag`. A Start clears `sel` and `rd_dir` but keeps both flags.
- R10: After a refused address byte, later bytes produce no `ack_vld` until the next Start.
- R11: A byte strobed in the same cycle as a Start or Stop is discarded: it produces no `ack_vld`, and the next byte is still taken as the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_det | input | 1 | Start or Repeated Start seen (one-cycle pulse) |
| stop_det | input | 1 | Stop seen (one-cycle pulse) |
| byte_vld | input | 1 | Received byte strobe |
| byte_in | input | 8 | Received byte, MSB first on the wire |
| cfg_addr | input | 10 | Own slave address |
| cfg_mask | input | 10 | Don't-care mask, 1 = ignore position |
| cfg_ten_bit | input | 1 | 1 = 10-bit addressing |
| cfg_gc_en | input | 1 | Accept general call |
| cfg_strict | input | 1 | Refuse reserved 7-bit addresses |
| ack_vld | output | 1 | Verdict for the last address byte is valid |
| ack_hit | output | 1 | Verdict: 1 = acknowledge |
| sel | output | 1 | Slave selected, data phase |
| rd_dir | output | 1 | Direction while selected, 1 = slave transmits |
| gc_flag | output | 1 | General call accepted since last Stop |
| ten_flag | output | 1 | 10-bit address matched since last Stop |

## Verification
The bench builds the block with its default parameters: a 5-bit 10-bit header prefix of 11110 and the protocol's 8-bit byte and 10-bit address. Both address modes, strict mode and general call are run-time inputs, so this one build covers every verdict path. This includes the mask-bit-0 asymmetry between the modes and the Repeated Start turnaround that relies on `ten_flag`. A different header prefix would only move the recognised header value; it opens no other path.

// File: rtl/i2c_am_pkg.sv
// Package: shared widths, the matcher phase type and the per-byte verdict record.
// Assumes bytes are 8 bits and addresses are at most 10 bits, as the protocol fixes.
package i2c_am_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int A7_W   = 7;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int PFX_W  = BYTE_W - HI_W - 1;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HDR  = 3'd1,
        PH_LOW  = 3'd2,
        PH_SEL  = 3'd3,
        PH_SKIP = 3'd4
    } am_phase_e;

    typedef struct packed {
        logic hit;
        logic go_low;
        logic sel;
        logic rd;
        logic gc;
        logic ten;
    } am_verdict_t;
endpackage

// File: rtl/am_mask_eq.sv
// Masked equality: eq is 1 when every position not marked don't-care agrees.
// Assumes dc bit 1 = ignore. Purely combinational.
module am_mask_eq #(
    parameter int W = 7
) (
    input  logic [W-1:0] rx,
    input  logic [W-1:0] ref_a,
    input  logic [W-1:0] dc,
    output logic         eq
);
    logic [W-1:0] diff;

    // Per-bit disagreement, masked out where don't-care.
    always_comb begin
        diff = (rx ^ ref_a) & ~dc;
        eq   = (diff == '0);
    end
endmodule

// File: rtl/am_classify.sv
// Classifier: gives the combinational verdict for the byte on byte_in in the
// current phase. Assumes phase_low is 1 only when a 10-bit low byte is expected.
module am_classify
    import i2c_am_pkg::*;
#(
    parameter logic [PFX_W-1:0] HDR_PFX = 5'b11110
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic              cfg_ten_bit,
    input  logic              cfg_gc_en,
    input  logic              cfg_strict,
    input  logic              phase_low,
    input  logic              ten_seen,
    output am_verdict_t       verdict
);
    localparam logic [3:0] RSV_LO = 4'b0000;
    localparam logic [3:0] RSV_HI = 4'b1111;

    logic              eq7, eq_hi, eq_lo;
    logic [A7_W-1:0]   dc7;
    logic              is_gc, is_hdr, is_rsv, rw;

    // 7-bit mask: address bit 0 is never a don't-care in this mode.
    always_comb dc7 = {cfg_mask[A7_W-1:1], 1'b0};

    am_mask_eq #(.W(A7_W)) u_eq7 (
        .rx(byte_in[BYTE_W-1:1]), .ref_a(cfg_addr[A7_W-1:0]), .dc(dc7), .eq(eq7)
    );
    am_mask_eq #(.W(HI_W)) u_eq_hi (
        .rx(byte_in[HI_W:1]), .ref_a(cfg_addr[ADDR_W-1:BYTE_W]),
        .dc(cfg_mask[ADDR_W-1:BYTE_W]), .eq(eq_hi)
    );
    am_mask_eq #(.W(BYTE_W)) u_eq_lo (
        .rx(byte_in), .ref_a(cfg_addr[BYTE_W-1:0]),
        .dc(cfg_mask[BYTE_W-1:0]), .eq(eq_lo)
    );

    // Byte classes used by every decision.
    always_comb begin
        is_gc  = (byte_in == '0);
        is_hdr = (byte_in[BYTE_W-1:HI_W+1] == HDR_PFX);
        is_rsv = (byte_in[BYTE_W-1:BYTE_W-4] == RSV_LO) ||
                 (byte_in[BYTE_W-1:BYTE_W-4] == RSV_HI);
        rw     = byte_in[0];
    end

    // Verdict selection by phase and mode.
    always_comb begin
        verdict = '0;
        if (phase_low) begin
            verdict.hit = eq_lo;
            verdict.sel = eq_lo;
            verdict.ten = eq_lo;
        end else if (is_gc) begin
            verdict.hit = cfg_gc_en;
            verdict.sel = cfg_gc_en;
            verdict.gc  = cfg_gc_en;
        end else if (cfg_ten_bit) begin
            if (is_hdr && eq_hi) begin
                if (!rw) begin
                    verdict.hit    = 1'b1;
                    verdict.go_low = 1'b1;
                end else if (ten_seen) begin
                    verdict.hit = 1'b1;
                    verdict.sel = 1'b1;
                    verdict.rd  = 1'b1;
                end
            end
        end else if (eq7 && !(cfg_strict && is_rsv)) begin
            verdict.hit = 1'b1;
            verdict.sel = 1'b1;
            verdict.rd  = rw;
        end
    end
endmodule

// File: rtl/am_seq.sv
// Sequencer: holds the matcher phase and status flags and registers the verdict.
// Assumes start_det and stop_det are single-cycle pulses; Stop wins if both come.
module am_seq
    import i2c_am_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic        byte_vld,
    input  am_verdict_t verdict,
    output logic        phase_low,
    output logic        ack_vld,
    output logic        ack_hit,
    output logic        sel,
    output logic        rd_dir,
    output logic        gc_flag,
    output logic        ten_flag
);
    am_phase_e phase;
    logic      take;

    // An address byte is taken only in an address phase and without a bus event.
    always_comb begin
        take      = byte_vld && !start_det && !stop_det &&
                    ((phase == PH_HDR) || (phase == PH_LOW));
        phase_low = (phase == PH_LOW);
    end

    // Phase, verdict and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            ack_vld  <= 1'b0;
            ack_hit  <= 1'b0;
            sel      <= 1'b0;
            rd_dir   <= 1'b0;
            gc_flag  <= 1'b0;
            ten_flag <= 1'b0;
        end else if (stop_det) begin
            phase    <= PH_IDLE;
            ack_vld  <= 1'b0;
            ack_hit  <= 1'b0;
            sel      <= 1'b0;
            rd_dir   <= 1'b0;
            gc_flag  <= 1'b0;
            ten_flag <= 1'b0;
        end else if (start_det) begin
            phase    <= PH_HDR;
            ack_vld  <= 1'b0;
            ack_hit  <= 1'b0;
            sel      <= 1'b0;
            rd_dir   <= 1'b0;
        end else begin
            ack_vld <= take;
            ack_hit <= take && verdict.hit;
            if (take) begin
                if (verdict.sel)         phase <= PH_SEL;
                else if (verdict.go_low) phase <= PH_LOW;
                else                     phase <= PH_SKIP;
                sel    <= verdict.sel;
                rd_dir <= verdict.rd;
                if (verdict.gc)  gc_flag  <= 1'b1;
                if (verdict.ten) ten_flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
// Top: I2C slave address matcher. Joins the byte classifier and the sequencer.
// Assumes a byte receiver upstream that pulses byte_vld once per complete byte.
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter logic [PFX_W-1:0] HDR_PFX = 5'b11110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic              cfg_ten_bit,
    input  logic              cfg_gc_en,
    input  logic              cfg_strict,
    output logic              ack_vld,
    output logic              ack_hit,
    output logic              sel,
    output logic              rd_dir,
    output logic              gc_flag,
    output logic              ten_flag
);
    am_verdict_t verdict;
    logic        phase_low;

    am_classify #(.HDR_PFX(HDR_PFX)) u_cls (
        .byte_in(byte_in), .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
        .cfg_ten_bit(cfg_ten_bit), .cfg_gc_en(cfg_gc_en), .cfg_strict(cfg_strict),
        .phase_low(phase_low), .ten_seen(ten_flag), .verdict(verdict)
    );

    am_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .byte_vld(byte_vld), .verdict(verdict), .phase_low(phase_low),
        .ack_vld(ack_vld), .ack_hit(ack_hit), .sel(sel), .rd_dir(rd_dir),
        .gc_flag(gc_flag), .ten_flag(ten_flag)
    );
endmodule

// File: rtl/am_checker.sv
// Checker: temporal properties of the matcher ports, bound to the top module.
module am_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_det,
    input logic       stop_det,
    input logic       byte_vld,
    input logic [7:0] byte_in,
    input logic       cfg_ten_bit,
    input logic       cfg_gc_en,
    input logic       cfg_strict,
    input logic       ack_vld,
    input logic       ack_hit,
    input logic       sel,
    input logic       rd_dir,
    input logic       gc_flag,
    input logic       ten_flag
);
    assert_vld_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(byte_vld));
    assert_hit_needs_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |-> ack_vld);
    assert_sel_from_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel) |-> ack_hit);
    assert_rd_only_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dir |-> sel);
    assert_gc_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_flag) |-> ($past(cfg_gc_en) && $past(byte_in) == 8'h00));
    assert_strict_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && cfg_strict && !cfg_ten_bit && byte_in[7:4] == 4'hF) |=> !ack_hit);
    assert_ten_in_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ten_flag) |-> $past(cfg_ten_bit));
    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sel && !gc_flag && !ten_flag));
    assert_event_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !ack_vld);
endmodule

bind i2c_addr_match am_checker u_am_chk (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .byte_vld(byte_vld), .byte_in(byte_in), .cfg_ten_bit(cfg_ten_bit),
    .cfg_gc_en(cfg_gc_en), .cfg_strict(cfg_strict), .ack_vld(ack_vld),
    .ack_hit(ack_hit), .sel(sel), .rd_dir(rd_dir), .gc_flag(gc_flag),
    .ten_flag(ten_flag)
);

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_det = 1'b0, stop_det = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [9:0] cfg_addr = 10'h000, cfg_mask = 10'h000;
    logic       cfg_ten_bit = 1'b0, cfg_gc_en = 1'b0, cfg_strict = 1'b0;
    logic       ack_vld, ack_hit, sel, rd_dir, gc_flag, ten_flag;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    i2c_addr_match u_i2c_addr_match (.*);

    // Reference model: phase as integer, 0 idle 1 header 2 low 3 selected 4 skip
    int m_ph = 0;
    bit m_vld = 0, m_hit = 0, m_sel = 0, m_rd = 0, m_gc = 0, m_ten = 0;

    function automatic bit masked_match(int rx, int own, int dc);
        return ((rx ^ own) & ~dc) == 0;
    endfunction

    always @(posedge clk) begin
        bit take, h, s, r, lo;
        int a7;
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_vld = 0; m_hit = 0; m_sel = 0; m_rd = 0; m_gc = 0; m_ten = 0;
        end else if (stop_det) begin
            m_ph = 0; m_vld = 0; m_hit = 0; m_sel = 0; m_rd = 0; m_gc = 0; m_ten = 0;
        end else if (start_det) begin
            m_ph = 1; m_vld = 0; m_hit = 0; m_sel = 0; m_rd = 0;
        end else begin
            take = byte_vld && (m_ph == 1 || m_ph == 2);
            h = 0; s = 0; r = 0; lo = 0;
            if (take) begin
                if (m_ph == 2) begin
                    h = masked_match(byte_in, cfg_addr & 8'hFF, cfg_mask & 8'hFF);
                    s = h;
                    if (h) m_ten = 1;
                end else if (byte_in == 0) begin
                    h = cfg_gc_en; s = h;
                    if (h) m_gc = 1;
                end else if (cfg_ten_bit) begin
                    if ((byte_in >> 3) == 5'b11110 &&
                        masked_match((byte_in >> 1) & 3, cfg_addr >> 8, cfg_mask >> 8)) begin
                        if (byte_in[0] == 0) begin h = 1; lo = 1; end
                        else if (m_ten) begin h = 1; s = 1; r = 1; end
                    end
                end else begin
                    a7 = byte_in >> 1;
                    h = masked_match(a7, cfg_addr & 7'h7F, cfg_mask & 7'h7E);
                    if (cfg_strict && ((a7 >> 3) == 0 || (a7 >> 3) == 15)) h = 0;
                    s = h; r = h && byte_in[0];
                end
                m_ph = s ? 3 : (lo ? 2 : 4);
                m_sel = s; m_rd = r;
            end
            m_vld = take; m_hit = take && h;
        end
    end

    task automatic chk(bit act, bit exp, string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", what, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) if (rst_n && !done) begin
        chk(ack_vld, m_vld, "R2 ack_vld vs model");
        chk(ack_hit, m_hit, "R2 ack_hit vs model");
        chk(sel, m_sel, "R10 sel vs model");
        chk(rd_dir, m_rd, "R3 rd_dir vs model");
        chk(gc_flag, m_gc, "R4 gc_flag vs model");
        chk(ten_flag, m_ten, "R7 ten_flag vs model");
    end

    task automatic pulse_start();
        @(negedge clk); start_det = 1; @(negedge clk); start_det = 0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop_det = 1; @(negedge clk); stop_det = 0;
    endtask
    // Strobe one byte; returns at the negedge where the verdict is visible.
    task automatic send(logic [7:0] b);
        @(negedge clk); byte_vld = 1; byte_in = b;
        @(negedge clk); byte_vld = 0;
    endtask
    task automatic verdict(bit v, bit h, string tag);
        chk(ack_vld, v, {tag, " ack_vld"});
        chk(ack_hit, h, {tag, " ack_hit"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ack_vld | ack_hit | sel | rd_dir | gc_flag | ten_flag, 0, "R1 outputs in reset");
        rst_n = 1;
        @(negedge clk);
        chk(ack_vld | ack_hit | sel | rd_dir | gc_flag | ten_flag, 0, "R1 outputs after reset");

        cfg_addr = 10'h02A;
        send(8'h55); verdict(0, 0, "R2 byte before start");
        // 7-bit read hit
        pulse_start(); send(8'h55); verdict(1, 1, "R3 7-bit read");
        chk(sel, 1, "R3 sel"); chk(rd_dir, 1, "R3 rd_dir read");
        send(8'h12); verdict(0, 0, "R2 data byte while selected");
        pulse_stop(); chk(sel | rd_dir, 0, "R9 stop clears sel");
        // mask on bits 2:1
        cfg_mask = 10'h006;
        pulse_start(); send(8'h58); verdict(1, 1, "R3 masked bits 2:1");
        chk(rd_dir, 0, "R3 rd_dir write");
        // mask bit 0 not honoured in 7-bit mode
        cfg_mask = 10'h001;
        pulse_start(); send(8'h56); verdict(1, 0, "R3 mask bit0 ignored 7-bit");
        send(8'h54); verdict(0, 0, "R10 after miss");
        pulse_start(); send(8'h54); verdict(1, 1, "R10 new start re-arms");
        pulse_stop();
        cfg_mask = 0;
        // general call
        pulse_start(); send(8'h00); verdict(1, 0, "R4 gc disabled");
        cfg_gc_en = 1;
        pulse_start(); send(8'h00); verdict(1, 1, "R4 gc enabled");
        chk(gc_flag, 1, "R4 gc_flag set");
        pulse_start(); chk(gc_flag, 1, "R9 start keeps gc_flag");
        chk(sel, 0, "R9 start clears sel");
        pulse_stop(); chk(gc_flag, 0, "R9 stop clears gc_flag");
        // strict reserved rule
        cfg_addr = 10'h07A;
        pulse_start(); send(8'hF4); verdict(1, 1, "R5 non-strict reserved");
        cfg_strict = 1;
        pulse_start(); send(8'hF4); verdict(1, 0, "R5 strict 1111xxx");
        cfg_addr = 10'h005;
        pulse_start(); send(8'h0A); verdict(1, 0, "R5 strict 0000xxx");
        pulse_stop();
        cfg_strict = 0;
        // 10-bit
        cfg_ten_bit = 1; cfg_addr = 10'h2A5;
        pulse_start(); send(8'hF5); verdict(1, 0, "R8 read header without prior match");
        pulse_start(); send(8'hF4); verdict(1, 1, "R6 header");
        chk(sel, 0, "R6 not yet selected");
        send(8'hA5); verdict(1, 1, "R7 low byte");
        chk(ten_flag, 1, "R7 ten_flag"); chk(sel, 1, "R7 sel"); chk(rd_dir, 0, "R7 write");
        pulse_start(); chk(ten_flag, 1, "R9 start keeps ten_flag");
        send(8'hF5); verdict(1, 1, "R8 turnaround header");
        chk(rd_dir, 1, "R8 rd_dir read");
        pulse_stop(); chk(ten_flag, 0, "R9 stop clears ten_flag");
        pulse_start(); send(8'hF4); send(8'hA4); verdict(1, 0, "R7 low byte miss");
        cfg_mask = 10'h001;
        pulse_start(); send(8'hF4); send(8'hA4); verdict(1, 1, "R7 low mask bit0");
        pulse_stop();
        pulse_start(); send(8'hF2); verdict(1, 0, "R6 header bits miss");
        cfg_mask = 10'h300;
        pulse_start(); send(8'hF2); verdict(1, 1, "R6 header bits masked");
        pulse_start(); send(8'h54); verdict(1, 0, "R6 non-header in 10-bit");
        pulse_stop();
        // priority of bus events over a byte
        cfg_ten_bit = 0; cfg_addr = 10'h02A; cfg_mask = 0;
        @(negedge clk); start_det = 1; byte_vld = 1; byte_in = 8'h54;
        @(negedge clk); start_det = 0; byte_vld = 0;
        verdict(0, 0, "R11 byte with start discarded");
        send(8'h54); verdict(1, 1, "R11 next byte is address");
        @(negedge clk); stop_det = 1; byte_vld = 1; byte_in = 8'h54;
        @(negedge clk); stop_det = 0; byte_vld = 0;
        verdict(0, 0, "R11 byte with stop discarded");
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) if (cyc > 20000 && !done) begin
        done = 1;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule